// File: doc/BRIEF.md
# GPIO Interrupt Front End

This block turns a bank of general-purpose input pins into one interrupt request line per pin, ready to feed a platform interrupt controller. Each pin is brought into the core clock domain by a two-flop synchronizer. Its synchronized value is then examined either as a level or as an edge, with a per-pin polarity. An event that is detected while the pin is enabled sets a sticky pending bit. The interrupt line for a pin is asserted when that pending bit is set and both the pin's enable bit and its mask bit are set.

Software configures the pins through a small 32-bit register bus. The registers sit at word offsets from the block's base address in the peripheral region. A handler that has serviced a pin writes a one to that pin's bit in the clear register. In edge mode this retires the event. In level mode the pending bit is set again for as long as the pin stays at its active level.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable, mask, trigger-mode, polarity and pending registers read as zero, and every interrupt line is low.
- R2: The enable (offset 0x00), mask (0x04), trigger-mode (0x08) and polarity (0x0C) registers are read/write full words. The clear register (0x10) always reads zero. Any unmapped offset, or any address with bits [1:0] not zero, reads zero and ignores writes.
- R3: A pin change first reaches the pending register at the third rising clock edge after the change: two synchronizer flops, then the pending flop.
- R4: Trigger-mode bit 0 selects level detection and bit 1 selects edge detection. Polarity bit 0 selects active-low or falling, and bit 1 selects active-high or rising.
- R5: In level mode the pending bit stays set while the active level persists, even when a clear is written. Once the level is gone, a clear removes it.
- R6: In edge mode, a single edge of the chosen polarity sets the pending bit once. The bit holds until it is cleared, and edges of the opposite polarity set nothing.
- R7: Writing to the clear register at 0x10 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Writes to the pending register at 0x14 have no effect.
- R8: A detected event sets the pending bit only while that pin's enable bit is 1. Enabling a pin later does not recover an event that was missed.
- R9: An interrupt line is high exactly when its pending, enable and mask bits are all 1. Clearing the mask hides a pending event without losing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS (32) | Asynchronous pin inputs |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | NPINS (32) | Per-pin interrupt request |

## Verification
The embedded assertions check, on every cycle, that the synchronizer delays pins by exactly two cycles and that a raw rising edge never fires on two consecutive cycles. They also check that pending bits appear only on enabled pins, that pending bits neither appear nor vanish without a cause, and that a clear retires every bit it names that no new event is setting again. Only the bench scenarios can show the end-to-end behaviour: the three-cycle latency seen at the ports, level re-assertion through a clear, opposite-polarity edges being ignored, masking that preserves an event, and the register map. The bench's reference model covers these cycle by cycle, under both directed and random pin and configuration traffic.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  // Word indices of the register map (byte offset = index * 4)
  typedef enum logic [3:0] {
    RSEL_ENA   = 4'd0,
    RSEL_MASK  = 4'd1,
    RSEL_TRIG  = 4'd2,
    RSEL_POL   = 4'd3,
    RSEL_CLR   = 4'd4,
    RSEL_PEND  = 4'd5,
    RSEL_NONE  = 4'd15
  } rsel_e;

  localparam int BUS_W = 32;

  // Event for one pin: trig=0 level, trig=1 edge; pol=1 high/rising
  function automatic logic pin_event(input logic trig, input logic pol,
                                     input logic cur, input logic old);
    logic rise, fall;
    rise = cur & ~old;
    fall = ~cur & old;
    if (trig) return pol ? rise : fall;
    else      return pol ? cur : ~cur;
  endfunction

  // Next state of a pending vector: new events win over clears
  function automatic logic [BUS_W-1:0] pend_next(input logic [BUS_W-1:0] pend,
                                                 input logic [BUS_W-1:0] clr,
                                                 input logic [BUS_W-1:0] set);
    return (pend & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] old_o
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pin_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= stg[STAGES-1];
  end

  assign cur_o = stg[STAGES-1];
  assign old_o = old_q;

  // Cycles since reset, saturating at STAGES, so $past never reaches into reset
  localparam int CW = $clog2(STAGES + 1);
  logic [CW-1:0] up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            up_q <= '0;
    else if (up_q != CW'(STAGES))          up_q <= up_q + 1'b1;
  end

  // R3
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == CW'(STAGES)) |-> (cur_o == $past(pin_i, STAGES)));

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] rise_o
);
  import gpirq_pkg::*;

  for (genvar p = 0; p < W; p++) begin : g_pin
    assign evt_o[p]  = pin_event(trig_i[p], pol_i[p], cur_i[p], old_i[p]);
    assign rise_o[p] = cur_i[p] & ~old_i[p];
  end

  // R6: a raw rising edge can never repeat on the next cycle
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [W-1:0]      evt_i,
  output logic [W-1:0]      trig_o,
  output logic [W-1:0]      pol_o,
  output logic [31:0]       bus_rdata,
  output logic [W-1:0]      irq_o
);
  import gpirq_pkg::*;

  logic [W-1:0] ena_q, mask_q, trig_q, pol_q, pend_q;
  rsel_e        sel;
  logic         wr;
  logic         clr_wr;
  logic [W-1:0] wval;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] rd_val;

  // Address decode: word aligned, mapped indices only
  always_comb begin
    sel = RSEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr[ADDR_W-1:2])
        (ADDR_W-2)'(0): sel = RSEL_ENA;
        (ADDR_W-2)'(1): sel = RSEL_MASK;
        (ADDR_W-2)'(2): sel = RSEL_TRIG;
        (ADDR_W-2)'(3): sel = RSEL_POL;
        (ADDR_W-2)'(4): sel = RSEL_CLR;
        (ADDR_W-2)'(5): sel = RSEL_PEND;
        default:        sel = RSEL_NONE;
      endcase
    end
  end

  assign wr       = bus_en & bus_we;
  assign wval     = bus_wdata[W-1:0];
  assign clr_wr   = wr & (sel == RSEL_CLR);
  assign set_bits = evt_i & ena_q;
  assign clr_bits = clr_wr ? wval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      mask_q <= '0;
      trig_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      case (sel)
        RSEL_ENA:  ena_q  <= wval;
        RSEL_MASK: mask_q <= wval;
        RSEL_TRIG: trig_q <= wval;
        RSEL_POL:  pol_q  <= wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= W'(pend_next(BUS_W'(pend_q), BUS_W'(clr_bits), BUS_W'(set_bits)));
  end

  always_comb begin
    case (sel)
      RSEL_ENA:  rd_val = ena_q;
      RSEL_MASK: rd_val = mask_q;
      RSEL_TRIG: rd_val = trig_q;
      RSEL_POL:  rd_val = pol_q;
      RSEL_PEND: rd_val = pend_q;
      default:   rd_val = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[W-1:0] = rd_val;
  end

  assign trig_o = trig_q;
  assign pol_o  = pol_q;
  assign irq_o  = pend_q & ena_q & mask_q;

  // R8
  pend_needs_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(ena_q)) == '0));

  // R7
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((wval & ~set_bits) != '0)) |=> ((pend_q & $past(wval & ~set_bits)) == '0));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && set_bits == '0) |=> $stable(pend_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NPINS-1:0]  irq_o
);

  logic [NPINS-1:0] cur_s, old_s, trig_s, pol_s, evt_s, rise_s;

  gpirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur_s), .old_o(old_s)
  );

  gpirq_detect #(.W(NPINS)) i_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(cur_s), .old_i(old_s),
    .trig_i(trig_s), .pol_i(pol_s), .evt_o(evt_s), .rise_o(rise_s)
  );

  gpirq_regs #(.W(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_i(evt_s),
    .trig_o(trig_s), .pol_o(pol_s), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // R9: an interrupt line only rises on a cycle after a change in the block's registers
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~$past(evt_s)) == '0) || $past(bus_en && bus_we));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h14;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ena, m_mask, m_trig, m_pol, m_pend;
  logic [31:0] hist[$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ena;
      8'h04: return m_mask;
      8'h08: return m_trig;
      8'h0C: return m_pol;
      8'h14: return m_pend;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ena = 0; m_mask = 0; m_trig = 0; m_pol = 0; m_pend = 0;
      hist.delete();
    end else begin
      logic [31:0] now_v, was_v;
      now_v = (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
      was_v = (hist.size() >= 3) ? hist[hist.size()-3] : 32'h0;
      for (int i = 0; i < 32; i++) begin
        bit hit;
        if (m_trig[i] == 1'b0) hit = (now_v[i] == m_pol[i]);
        else if (m_pol[i])     hit = now_v[i] && !was_v[i];
        else                   hit = !now_v[i] && was_v[i];
        if (hit && m_ena[i]) m_pend[i] = 1'b1;
        else if (bus_en && bus_we && bus_addr == 8'h10 && bus_wdata[i]) m_pend[i] = 1'b0;
      end
      if (bus_en && bus_we) begin
        case (bus_addr)
          8'h00: m_ena  = bus_wdata;
          8'h04: m_mask = bus_wdata;
          8'h08: m_trig = bus_wdata;
          8'h0C: m_pol  = bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_i);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (irq_o !== (m_pend & m_ena & m_mask)) begin
        n_bad++;
        $display("FAIL R9 irq: actual %h expected %h at %0t", irq_o, m_pend & m_ena & m_mask, $time);
      end
      if (bus_en && !bus_we) begin
        n_cmp++;
        if (bus_rdata !== m_read(bus_addr)) begin
          n_bad++;
          $display("FAIL R2 read @%h: actual %h expected %h at %0t", bus_addr, bus_rdata, m_read(bus_addr), $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0; bus_addr = 8'h14;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); #1;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s @%h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
    bus_addr = 8'h14;
    tick();
  endtask

  task automatic chk_irq(input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    n_cmp++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq: actual %h expected %h", tag, irq_o, exp);
    end
    tick();
  endtask

  // Watchdog
  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1: reset state
    chk(8'h00, 0, "R1 ena");
    chk(8'h04, 0, "R1 mask");
    chk(8'h08, 0, "R1 trig");
    chk(8'h0C, 0, "R1 pol");
    chk(8'h14, 0, "R1 pend");
    chk_irq(0, "R1");

    // R2: register map
    wr(8'h08, 32'hA5A5_0F0F); chk(8'h08, 32'hA5A5_0F0F, "R2 trig");
    wr(8'h0C, 32'h1234_5678); chk(8'h0C, 32'h1234_5678, "R2 pol");
    chk(8'h10, 0, "R2 clr reads zero");
    wr(8'h18, 32'hFFFF_FFFF); chk(8'h18, 0, "R2 unmapped");
    wr(8'h01, 32'hFFFF_FFFF); chk(8'h00, 0, "R2 misaligned write ignored");
    wr(8'h08, 0); wr(8'h0C, 0);

    // R3/R6: falling edge on pin 0, edge mode, enabled and masked in
    pin_i = 32'h0000_0001; tick(4);
    wr(8'h08, 32'h0000_0001); wr(8'h0C, 0);
    wr(8'h00, 32'h0000_0001); wr(8'h04, 32'h0000_0001);
    pin_i[0] = 0; tick(2);
    chk(8'h14, 0, "R3 not yet pending");
    chk(8'h14, 32'h1, "R3 pending after third edge");
    chk_irq(32'h1, "R9 irq raised");
    tick(5); chk(8'h14, 32'h1, "R6 edge pending holds");

    // R9: mask hides, does not lose
    wr(8'h04, 0); chk_irq(0, "R9 masked");
    chk(8'h14, 32'h1, "R9 pending kept under mask");
    wr(8'h04, 32'h1); chk_irq(32'h1, "R9 unmasked");

    // R7: write-one-to-clear, zeros and pending writes ignored
    wr(8'h10, 32'hFFFF_FFFE); chk(8'h14, 32'h1, "R7 zero bit keeps");
    wr(8'h14, 32'h0); chk(8'h14, 32'h1, "R7 pending write ignored");
    wr(8'h10, 32'h1); chk(8'h14, 0, "R7 clear");
    // R6: opposite-polarity (rising) edge sets nothing
    pin_i[0] = 1; tick(5); chk(8'h14, 0, "R6 opposite edge");

    // R5: level high on pin 5
    wr(8'h0C, 32'h0000_0020); wr(8'h00, 32'h0000_0021);
    pin_i[5] = 1; tick(4);
    chk(8'h14, 32'h20, "R4 high level");
    wr(8'h10, 32'h20); chk(8'h14, 32'h20, "R5 level survives clear");
    pin_i[5] = 0; tick(4);
    wr(8'h10, 32'h20); chk(8'h14, 0, "R5 clear after level gone");

    // R4: active-low level on pin 9 (polarity 0, trigger 0)
    pin_i[9] = 1; tick(4);
    wr(8'h00, 32'h0000_0200); tick(3); chk(8'h14, 0, "R4 low level inactive");
    pin_i[9] = 0; tick(4); chk(8'h14, 32'h200, "R4 low level");
    pin_i[9] = 1; tick(4); wr(8'h10, 32'h200);

    // R8: edge on a disabled pin is lost
    wr(8'h08, 32'h0000_0080); wr(8'h0C, 32'h0000_0080); wr(8'h00, 0);
    pin_i[7] = 1; tick(5);
    wr(8'h00, 32'h80); tick(4); chk(8'h14, 0, "R8 missed edge stays lost");
    pin_i[7] = 0; tick(4);
    pin_i[7] = 1; tick(4); chk(8'h14, 32'h80, "R8 edge while enabled");

    // Random traffic against the model
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0)      wr(8'h00, $urandom());
      else if (op == 1) wr(8'h04, $urandom());
      else if (op == 2) wr(8'h08, $urandom());
      else if (op == 3) wr(8'h0C, $urandom());
      else if (op == 4) wr(8'h10, $urandom());
      else if (op == 5) begin
        bus_en = 1; bus_addr = 8'h04 * 8'($urandom_range(0, 6)); tick();
      end else begin
        pin_i = pin_i ^ ($urandom() & $urandom());
        bus_addr = 8'h14; tick();
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule